// File: doc/BRIEF.md
# Keyed Low-Speed Clock Selector

This block picks the source of a chip's slow timekeeping clock. One candidate is an internal RC oscillator, whose pulses pass first through a fixed pre-divider and then through a divider of N+1 that software sets. The other is an external crystal input, which passes through undivided. Everything runs in one system clock domain. Each oscillator appears at the block's edge as a one-cycle enable pulse, and the selected low-speed clock leaves the block in the same form.

Software controls the block through a small register window. The control word changes only when the write carries a 16-bit key in its upper half, so a stray store cannot switch the timebase. If the crystal is flagged as failed and the fallback has not been bypassed, the block forces the internal source and reports it. A separate gate register lets the selected clock reach a clock-out enable.

Top module: `lsclk_selector`

## Requirements
- R1: After reset, all three registers read 0. The internal source is selected, and `ext_osc_en`, `losc_tick`, `clkout_tick` and `fallback` are 0.
- R2: A write to offset 0x00 takes effect only when `bus_wdata[31:16]` equals 16'h16AA. A write with any other upper half leaves every control bit unchanged. Bits 31:16 of a control read are always 0.
- R3: In the control word, bit 0 selects the source (1 = external, 0 = internal), bit 4 drives `ext_osc_en`, and bit 15 bypasses the fallback. All three read back at those positions.
- R4: On the internal path, `losc_tick` pulses once for every PRE_DIV*(N+1) `int_osc_tick` pulses (PRE_DIV = 32 by default). The pulse comes in the cycle after the input pulse that completes the count.
- R5: On the external path, `losc_tick` equals `ext_osc_tick` delayed by one cycle, with no division.
- R6: Offset 0x08 holds N in bits 4:0. Any write to it restarts the internal count, so the first internal output after the write comes after a full PRE_DIV*(N+1) pulses. An input pulse in the same cycle as the write is not counted.
- R7: While the external source is in use, the internal count is held at zero. On a return to the internal source, a full period passes before the first internal output.
- R8: If bit 0 = 1, bit 15 = 0 and `ext_fail` = 1, the internal path is used, `fallback` = 1 and control read bit 2 = 1. With bit 15 = 1, the external source is kept and `fallback` = 0.
- R9: Bit 0 at offset 0x60 gates the clock-out. `clkout_tick` equals `losc_tick` when the bit is 1 and is 0 otherwise.
- R10: Writes to unmapped offsets change nothing, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| int_osc_tick | input | 1 | Internal RC oscillator pulse |
| ext_osc_tick | input | 1 | External crystal pulse |
| ext_fail | input | 1 | External oscillator failure flag |
| ext_osc_en | output | 1 | External oscillator enable |
| losc_tick | output | 1 | Selected low-speed clock enable |
| clkout_tick | output | 1 | Gated clock-out enable |
| fallback | output | 1 | Forced internal selection is active |

## Verification
The bench keeps its own model of the pulse count and compares every output cycle against it. A divider off by one pulse, or one that does not restart on a prescaler write or on the return from the external source, moves the expected pulse position and is reported. Writes with no key and with a key one bit wrong are aimed at a design that checks only part of the key; such a design would switch the source. The fallback case is run both with and without the bypass bit, so a design that ignores either bit keeps the wrong source and shows a wrong status bit.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
   localparam int unsigned  REG_W       = 32;
   localparam logic [15:0]  CTRL_KEY    = 16'h16AA;
   localparam logic [7:0]   OFS_CTRL    = 8'h00;
   localparam logic [7:0]   OFS_PRESC   = 8'h08;
   localparam logic [7:0]   OFS_GATE    = 8'h60;
   localparam int unsigned  B_SRC       = 0;
   localparam int unsigned  B_FB_STAT   = 2;
   localparam int unsigned  B_XEN       = 4;
   localparam int unsigned  B_BYP       = 15;

   typedef struct packed {
      logic byp;
      logic xen;
      logic sel;
   } ctrl_t;
endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
   import lsclk_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned PRESC_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   input  logic                fb_stat,
   output logic [REG_W-1:0]    bus_rdata,
   output ctrl_t               ctrl,
   output logic [PRESC_W-1:0]  presc_n,
   output logic                presc_load,
   output logic                gate_en
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFS_PRESC);
   localparam logic [ADDR_W-1:0] A_GATE  = ADDR_W'(OFS_GATE);

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("lsclk_regs: ADDR_W must reach offset 0x60");
      end
      if (PRESC_W < 1 || PRESC_W > 16) begin : g_bad_presc
         $error("lsclk_regs: PRESC_W out of range");
      end
   endgenerate

   logic   key_ok;
   logic   wr_ctrl, wr_gate;
   ctrl_t  ctrl_q;
   logic [PRESC_W-1:0] presc_q;
   logic   gate_q;
   logic   wdata_unused;

   assign key_ok     = (bus_wdata[REG_W-1:16] == CTRL_KEY);
   assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL) && key_ok;
   assign presc_load = bus_wr && (bus_addr == A_PRESC);
   assign wr_gate    = bus_wr && (bus_addr == A_GATE);
   assign wdata_unused = ^{bus_wdata[14:5], bus_wdata[3:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         presc_q <= '0;
         gate_q  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.sel <= bus_wdata[B_SRC];
            ctrl_q.xen <= bus_wdata[B_XEN];
            ctrl_q.byp <= bus_wdata[B_BYP];
         end
         if (presc_load) presc_q <= bus_wdata[PRESC_W-1:0];
         if (wr_gate)    gate_q  <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL) begin
         bus_rdata[B_SRC]     = ctrl_q.sel;
         bus_rdata[B_FB_STAT] = fb_stat;
         bus_rdata[B_XEN]     = ctrl_q.xen;
         bus_rdata[B_BYP]     = ctrl_q.byp;
      end else if (bus_addr == A_PRESC) begin
         bus_rdata[PRESC_W-1:0] = presc_q;
      end else if (bus_addr == A_GATE) begin
         bus_rdata[0] = gate_q;
      end
   end

   assign ctrl    = ctrl_q;
   assign presc_n = presc_q;
   assign gate_en = gate_q;

   // R2: a control write without the key must leave the control bits alone
   p_keyless_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL && bus_wdata[REG_W-1:16] != CTRL_KEY)
      |=> $stable(ctrl_q));
endmodule

// File: rtl/lsclk_div.sv
module lsclk_div #(
   parameter int unsigned PRE_DIV = 32,
   parameter int unsigned PRESC_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               int_tick,
   input  logic               reload,
   input  logic               hold,
   input  logic [PRESC_W-1:0] n_val,
   output logic               div_tick
);
   localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   generate
      if (PRE_DIV < 1) begin : g_bad_pre
         $error("lsclk_div: PRE_DIV must be at least 1");
      end
   endgenerate

   logic clear;
   logic pre_wrap;
   logic post_last;
   logic [PRESC_W-1:0] post_cnt;

   assign clear = reload | hold;

   generate
      if (PRE_DIV > 1) begin : g_pre
         logic [PRE_W-1:0] pre_cnt;
         assign pre_wrap = int_tick && (pre_cnt == PRE_W'(PRE_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || clear)  pre_cnt <= '0;
            else if (pre_wrap)    pre_cnt <= '0;
            else if (int_tick)    pre_cnt <= pre_cnt + 1'b1;
         end
      end else begin : g_nopre
         assign pre_wrap = int_tick;
      end
   endgenerate

   assign post_last = (post_cnt == n_val);

   always_ff @(posedge clk) begin
      if (!rst_n || clear)  post_cnt <= '0;
      else if (pre_wrap)    post_cnt <= post_last ? '0 : post_cnt + 1'b1;
   end

   assign div_tick = pre_wrap && post_last && !clear;

   // R4: the programmable stage never runs past its terminal value
   p_post_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> (post_cnt <= n_val));
endmodule

// File: rtl/lsclk_srcsel.sv
module lsclk_srcsel
   import lsclk_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  ctrl_t ctrl,
   input  logic  ext_fail,
   input  logic  ext_tick,
   input  logic  div_tick,
   input  logic  gate_en,
   output logic  use_ext,
   output logic  fb_active,
   output logic  losc_tick,
   output logic  clkout_tick
);
   logic pick;

   assign fb_active = ctrl.sel && !ctrl.byp && ext_fail;
   assign use_ext   = ctrl.sel && !fb_active;
   assign pick      = use_ext ? ext_tick : div_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         losc_tick   <= 1'b0;
         clkout_tick <= 1'b0;
      end else begin
         losc_tick   <= pick;
         clkout_tick <= pick && gate_en;
      end
   end

   // R5: external path passes each crystal pulse one cycle later
   p_ext_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      use_ext |=> (losc_tick == $past(ext_tick)));
   // R8: an unbypassed failure never keeps the external source
   p_fail_forces_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_fail && !ctrl.byp) |-> !use_ext);
endmodule

// File: rtl/lsclk_selector.sv
module lsclk_selector
   import lsclk_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned PRESC_W = 5,
   parameter int unsigned PRE_DIV = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              int_osc_tick,
   input  logic              ext_osc_tick,
   input  logic              ext_fail,
   output logic              ext_osc_en,
   output logic              losc_tick,
   output logic              clkout_tick,
   output logic              fallback
);
   ctrl_t              ctrl;
   logic [PRESC_W-1:0] presc_n;
   logic               presc_load;
   logic               gate_en;
   logic               use_ext;
   logic               fb_active;
   logic               div_tick;

   lsclk_regs #(.ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .fb_stat    (fb_active),
      .bus_rdata  (bus_rdata),
      .ctrl       (ctrl),
      .presc_n    (presc_n),
      .presc_load (presc_load),
      .gate_en    (gate_en)
   );

   lsclk_div #(.PRE_DIV(PRE_DIV), .PRESC_W(PRESC_W)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .int_tick (int_osc_tick),
      .reload   (presc_load),
      .hold     (use_ext),
      .n_val    (presc_n),
      .div_tick (div_tick)
   );

   lsclk_srcsel i_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl        (ctrl),
      .ext_fail    (ext_fail),
      .ext_tick    (ext_osc_tick),
      .div_tick    (div_tick),
      .gate_en     (gate_en),
      .use_ext     (use_ext),
      .fb_active   (fb_active),
      .losc_tick   (losc_tick),
      .clkout_tick (clkout_tick)
   );

   assign ext_osc_en = ctrl.xen;
   assign fallback   = fb_active;

   // R9: the clock-out never pulses without the selected clock
   p_gate_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clkout_tick |-> losc_tick);
   // R7: the internal divider is silent while the crystal is in use
   p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      use_ext |-> !div_tick);
endmodule

// File: tb/test_lsclk_selector.sv
module test_lsclk_selector;
   localparam int PRE = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        int_osc_tick = 1'b0;
   logic        ext_osc_tick = 1'b0;
   logic        ext_fail = 1'b0;
   logic        ext_osc_en, losc_tick, clkout_tick, fallback;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   string cur_req = "R1";
   int int_div = 0;
   bit ext_mode = 0;
   int cyc = 0;

   // model state
   bit m_sel, m_xen, m_byp, m_gate;
   int m_n, m_cnt;
   logic [1:0] sb_q[$];

   lsclk_selector i_lsclk_selector (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .int_osc_tick(int_osc_tick), .ext_osc_tick(ext_osc_tick),
      .ext_fail(ext_fail), .ext_osc_en(ext_osc_en), .losc_tick(losc_tick),
      .clkout_tick(clkout_tick), .fallback(fallback));

   always #4 clk = ~clk;

   // pulse sources
   always @(negedge clk) begin
      cyc <= cyc + 1;
      int_osc_tick <= (int_div != 0) && (cyc % int_div == 0);
      ext_osc_tick <= ext_mode && ((cyc % 3 == 0) || (cyc % 7 == 0));
   end

   // driver-side model: push expected outputs for the edge just taken
   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel = 0; m_xen = 0; m_byp = 0; m_gate = 0; m_n = 0; m_cnt = 0;
      end else begin
         bit fb, ue, wp, et, ec;
         int per;
         fb  = m_sel && !m_byp && ext_fail;
         ue  = m_sel && !fb;
         wp  = bus_wr && (bus_addr == 8'h08);
         per = PRE * (m_n + 1);
         if (ue) et = ext_osc_tick;
         else    et = int_osc_tick && !wp && (m_cnt == per - 1);
         ec = et && m_gate;
         sb_q.push_back({et, ec});
         if (wp || ue) m_cnt = 0;
         else if (int_osc_tick) m_cnt = (m_cnt == per - 1) ? 0 : m_cnt + 1;
         if (bus_wr) begin
            if (bus_addr == 8'h00 && bus_wdata[31:16] == 16'h16AA) begin
               m_sel = bus_wdata[0]; m_xen = bus_wdata[4]; m_byp = bus_wdata[15];
            end
            if (bus_addr == 8'h08) m_n = int'(bus_wdata[4:0]);
            if (bus_addr == 8'h60) m_gate = bus_wdata[0];
         end
      end
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && sb_q.size() > 0) begin
         logic [1:0] e;
         e = sb_q.pop_front();
         n_cmp++;
         if (losc_tick !== e[1]) begin
            n_bad++;
            $display("FAIL %s losc_tick cyc=%0d actual=%b expected=%b", cur_req, cyc, losc_tick, e[1]);
         end
         n_cmp++;
         if (clkout_tick !== e[0]) begin
            n_bad++;
            $display("FAIL %s clkout_tick cyc=%0d actual=%b expected=%b", cur_req, cyc, clkout_tick, e[0]);
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 32'h0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_up();
      end
   end

   initial begin
      run(4);
      // R1 reset state
      rd_chk("R1", 8'h00, 32'h0);
      rd_chk("R1", 8'h08, 32'h0);
      rd_chk("R1", 8'h60, 32'h0);
      chk("R1", {31'h0, ext_osc_en}, 32'h0);
      chk("R1", {29'h0, losc_tick, clkout_tick, fallback}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // R4 internal path, pulse every cycle, N=0
      cur_req = "R4"; int_div = 1; run(100);
      // R6 prescaler write mid-count, slower source
      cur_req = "R6"; int_div = 3;
      bus_write(8'h08, 32'h0000_0002); run(320);
      rd_chk("R6", 8'h08, 32'h2);
      run(50);
      bus_write(8'h08, 32'hFFFF_FFE1); run(250);
      rd_chk("R6", 8'h08, 32'h1);

      // R2 keyless and wrong-key control writes
      cur_req = "R2";
      bus_write(8'h00, 32'h0000_8011);
      rd_chk("R2", 8'h00, 32'h0);
      bus_write(8'h00, 32'h16AB_8011);
      rd_chk("R2", 8'h00, 32'h0);
      chk("R2", {31'h0, ext_osc_en}, 32'h0);
      run(60);

      // R3 / R5 keyed switch to external
      cur_req = "R5"; ext_mode = 1;
      bus_write(8'h00, 32'h16AA_0011);
      rd_chk("R3", 8'h00, 32'h0000_0011);
      chk("R3", {31'h0, ext_osc_en}, 32'h1);
      run(100);

      // R8 failure forces internal
      cur_req = "R8"; ext_fail = 1'b1; run(2);
      chk("R8", {31'h0, fallback}, 32'h1);
      rd_chk("R8", 8'h00, 32'h0000_0015);
      run(250);
      bus_write(8'h00, 32'h16AA_8011);
      chk("R8", {31'h0, fallback}, 32'h0);
      rd_chk("R8", 8'h00, 32'h0000_8011);
      run(60);

      // R7 return to internal from external
      cur_req = "R7"; ext_fail = 1'b0;
      bus_write(8'h00, 32'h16AA_0000); ext_mode = 0;
      chk("R7", {31'h0, ext_osc_en}, 32'h0);
      run(250);

      // R9 clock-out gating
      cur_req = "R9"; int_div = 1;
      bus_write(8'h60, 32'h1);
      rd_chk("R9", 8'h60, 32'h1);
      run(140);
      bus_write(8'h60, 32'h0);
      run(100);

      // R10 unmapped offset
      cur_req = "R10";
      bus_write(8'h04, 32'hFFFF_FFFF);
      rd_chk("R10", 8'h04, 32'h0);
      rd_chk("R10", 8'h00, 32'h0);
      rd_chk("R10", 8'h08, 32'h1);
      rd_chk("R10", 8'h60, 32'h0);
      run(10);

      done = 1;
      finish_up();
   end
endmodule